// File: doc/BRIEF.md
# Accumulator Arithmetic and Logic Unit with Status Flags

This block is the arithmetic core that sits beside an accumulator and a companion register. Each clock cycle it takes an operation code, the accumulator value, a second operand and the incoming carry, auxiliary-carry and overflow flags. It computes the new accumulator byte, the new companion-register byte and a fresh set of four status flags: carry, auxiliary carry, overflow and parity. All outputs are registered, so a result appears one clock edge after its operands are presented.

Eight operations are supported: add, add with carry, subtract with borrow, bitwise AND, OR and XOR, an unsigned multiply and an unsigned divide. Multiply and divide spread their result over both output bytes. The other operations pass the second operand through unchanged on the companion output. Each flag follows a fixed rule for each operation class. Logical operations only refresh parity. Multiply and divide force carry low and use overflow to report a product wider than one byte or a zero divisor.

The surrounding sequencer feeds the registered outputs back into its accumulator, companion register and flag register. The data width is a parameter with a default of 8. The auxiliary carry is taken at the midpoint of the word.

Top module: `aalu_core`

## Requirements
- R1: While `rst_n` is low at a rising clock edge, every output is cleared to zero on that edge.
- R2: Outputs are registered. The values presented at one rising edge appear on the outputs right after that edge. The `op_i` encoding is 0 add, 1 add with carry, 2 subtract with borrow, 3 AND, 4 OR, 5 XOR, 6 multiply, 7 divide.
- R3: Add produces `a_i + b_i` and add with carry produces `a_i + b_i + cy_i`, both modulo 256 on `res_lo_o`. `cy_o` is the carry out of bit 7.
- R4: For add and add with carry, `ac_o` is the carry out of bit 3. For subtract with borrow, `ac_o` is the borrow into bit 3 from bit 4.
- R5: For add, add with carry and subtract with borrow, `ov_o` is set when exactly one of two events occurs: a carry into bit 7, or a carry out of bit 7. This equals signed two's-complement overflow.
- R6: Subtract with borrow produces `a_i - b_i - cy_i` modulo 256. `cy_o` is set when that difference is negative.
- R7: For every operation, `par_o` is 1 when `res_lo_o` holds an odd number of ones and 0 otherwise.
- R8: AND, OR and XOR put the bitwise result on `res_lo_o` and pass `cy_i`, `ac_i` and `ov_i` through unchanged.
- R9: Multiply places the low product byte on `res_lo_o` and the high byte on `res_hi_o`. It clears `cy_o`, passes `ac_i` through, and sets `ov_o` when the product exceeds 255.
- R10: Divide with a nonzero divisor places the quotient `a_i / b_i` on `res_lo_o` and the remainder on `res_hi_o`. It clears `cy_o` and `ov_o`, and passes `ac_i` through.
- R11: Divide by zero sets `ov_o`, clears `cy_o`, passes `ac_i` through, and returns `a_i` on `res_lo_o` and `b_i` on `res_hi_o`, so both registers keep their old values.
- R12: For add, add with carry, subtract with borrow and the logical operations, `res_hi_o` equals `b_i`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| op_i | input | 3 | Operation code |
| a_i | input | W | Accumulator operand |
| b_i | input | W | Second operand / companion register |
| cy_i | input | 1 | Incoming carry (borrow for subtract) |
| ac_i | input | 1 | Incoming auxiliary carry |
| ov_i | input | 1 | Incoming overflow |
| res_lo_o | output | W | New accumulator value |
| res_hi_o | output | W | New companion-register value |
| cy_o | output | 1 | Carry / borrow flag |
| ac_o | output | 1 | Auxiliary carry flag |
| ov_o | output | 1 | Overflow flag |
| par_o | output | 1 | Odd-parity flag of `res_lo_o` |

## Verification
Every accumulator value is swept against sixteen second-operand values spaced by 17, from 0 to 255, under every operation and both incoming carries. This range covers zero divisors, all-ones operands and both sign combinations. That is enough to separate a carry taken from the wrong bit, a borrow that is not inverted, and overflow confused with carry. The incoming auxiliary-carry and overflow flags are toggled from the operand bits, so a flag that should pass through but is recomputed or cleared shows up as a mismatch. Directed cases add a known small sum and a reset asserted in the middle of traffic.

// File: rtl/aalu_pkg.sv
// Package: shared operation codes for the accumulator ALU.
// Assumes a 3-bit operation field driven by the sequencer.
package aalu_pkg;

    typedef enum logic [2:0] {
        OP_ADD  = 3'd0,
        OP_ADDC = 3'd1,
        OP_SUBB = 3'd2,
        OP_AND  = 3'd3,
        OP_OR   = 3'd4,
        OP_XOR  = 3'd5,
        OP_MUL  = 3'd6,
        OP_DIV  = 3'd7
    } aalu_op_e;

    typedef enum logic [1:0] {
        LG_AND = 2'd0,
        LG_OR  = 2'd1,
        LG_XOR = 2'd2
    } aalu_lg_e;

endpackage

// File: rtl/aalu_addsub.sv
// Adder/subtractor with carry-chain taps.
// Computes a + b + cin, or a - b - borrow by adding the inverted operand.
// Reports the carry out of the midpoint and out of the top bit, inverted to
// borrows when subtracting. Overflow compares the carries into and out of the top bit.
// Assumes W >= HALF + 2.
module aalu_addsub #(
    parameter int W    = 8,
    parameter int HALF = W / 2
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic         cin,
    input  logic         sub,
    output logic [W-1:0] sum,
    output logic         cy,
    output logic         ac,
    output logic         ov
);
    localparam int MIDW = W - 1 - HALF;

    logic [W-1:0]  b_eff;
    logic          c_eff;
    logic [HALF:0] lo_sum;
    logic [MIDW:0] mid_sum;
    logic [1:0]    top_sum;
    logic          c_half;
    logic          c_into_top;
    logic          c_out;

    // Select the true or inverted operand and carry for the subtract path.
    always_comb begin
        b_eff = sub ? ~b : b;
        c_eff = sub ? ~cin : cin;
    end

    // Three slices expose the carry into bit HALF and the carry into the top bit.
    always_comb begin
        lo_sum     = {1'b0, a[HALF-1:0]} + {1'b0, b_eff[HALF-1:0]} + {{HALF{1'b0}}, c_eff};
        c_half     = lo_sum[HALF];
        mid_sum    = {1'b0, a[W-2:HALF]} + {1'b0, b_eff[W-2:HALF]} + {{MIDW{1'b0}}, c_half};
        c_into_top = mid_sum[MIDW];
        top_sum    = {1'b0, a[W-1]} + {1'b0, b_eff[W-1]} + {1'b0, c_into_top};
        c_out      = top_sum[1];
    end

    // Assemble the sum and the flags; a borrow is the complement of a carry.
    always_comb begin
        sum = {top_sum[0], mid_sum[MIDW-1:0], lo_sum[HALF-1:0]};
        cy  = sub ? ~c_out : c_out;
        ac  = sub ? ~c_half : c_half;
        ov  = c_into_top ^ c_out;
    end

endmodule

// File: rtl/aalu_logic.sv
// Bitwise unit: AND, OR or XOR of the two operands, chosen by sel.
// Assumes sel carries one of the three defined codes; any other code gives zero.
module aalu_logic #(
    parameter int W = 8
) (
    input  logic [W-1:0]       a,
    input  logic [W-1:0]       b,
    input  aalu_pkg::aalu_lg_e sel,
    output logic [W-1:0]       res
);
    import aalu_pkg::*;

    // Pick the requested bitwise function.
    always_comb begin
        unique case (sel)
            LG_AND:  res = a & b;
            LG_OR:   res = a | b;
            LG_XOR:  res = a ^ b;
            default: res = '0;
        endcase
    end

endmodule

// File: rtl/aalu_muldiv.sv
// Unsigned multiply and divide, both combinational.
// Multiply: {hi, lo} = a * b. Divide: lo = quotient, hi = remainder, using an
// unrolled restoring divider with one compare-subtract stage per quotient bit.
// Divide by zero returns a and b unchanged and raises ovf.
// Multiply raises ovf when the high byte is nonzero.
module aalu_muldiv #(
    parameter int W = 8
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic         is_div,
    output logic [W-1:0] lo,
    output logic [W-1:0] hi,
    output logic         ovf
);
    localparam int PW = 2 * W;

    logic [PW-1:0] prod;
    logic [W:0]    rem_stage [W+1];
    logic [W-1:0]  quot;
    logic          div_zero;

    // Full-width product.
    always_comb begin
        prod = PW'(a) * PW'(b);
    end

    assign rem_stage[0] = '0;

    // One restoring stage per quotient bit, from the most significant bit down.
    for (genvar s = 0; s < W; s++) begin : g_div_stage
        logic [W:0] shifted;
        logic       fits;
        always_comb begin
            shifted = {rem_stage[s][W-1:0], a[W-1-s]};
            fits    = (shifted >= {1'b0, b});
        end
        assign quot[W-1-s]    = fits;
        assign rem_stage[s+1] = fits ? (shifted - {1'b0, b}) : shifted;
    end

    assign div_zero = (b == '0);

    // Route the product or the quotient/remainder pair, with the overflow rule for each.
    always_comb begin
        if (is_div) begin
            if (div_zero) begin
                lo  = a;
                hi  = b;
                ovf = 1'b1;
            end else begin
                lo  = quot;
                hi  = rem_stage[W][W-1:0];
                ovf = 1'b0;
            end
        end else begin
            lo  = prod[W-1:0];
            hi  = prod[PW-1:W];
            ovf = (prod[PW-1:W] != '0);
        end
    end

endmodule

// File: rtl/aalu_core.sv
// Accumulator ALU top: decodes the operation, steers the operands to the
// add/subtract, bitwise and multiply/divide units, applies the flag rule for
// each operation class, and registers the two result bytes and four flags.
// Assumes a synchronous active-low reset and one operation per clock.
module aalu_core #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [2:0]   op_i,
    input  logic [W-1:0] a_i,
    input  logic [W-1:0] b_i,
    input  logic         cy_i,
    input  logic         ac_i,
    input  logic         ov_i,
    output logic [W-1:0] res_lo_o,
    output logic [W-1:0] res_hi_o,
    output logic         cy_o,
    output logic         ac_o,
    output logic         ov_o,
    output logic         par_o
);
    import aalu_pkg::*;

    aalu_op_e     op;
    logic         as_sub;
    logic         as_cin;
    logic [W-1:0] as_sum;
    logic         as_cy;
    logic         as_ac;
    logic         as_ov;
    aalu_lg_e     lg_sel;
    logic [W-1:0] lg_res;
    logic [W-1:0] md_lo;
    logic [W-1:0] md_hi;
    logic         md_ovf;
    logic [W-1:0] nx_lo;
    logic [W-1:0] nx_hi;
    logic         nx_cy;
    logic         nx_ac;
    logic         nx_ov;

    // Decode the operation and set up the add/subtract controls.
    always_comb begin
        op     = aalu_op_e'(op_i);
        as_sub = (op == OP_SUBB);
        as_cin = (op == OP_ADD) ? 1'b0 : cy_i;
    end

    // Map the logical operation codes onto the bitwise unit's selector.
    always_comb begin
        unique case (op)
            OP_OR:   lg_sel = LG_OR;
            OP_XOR:  lg_sel = LG_XOR;
            default: lg_sel = LG_AND;
        endcase
    end

    aalu_addsub #(.W(W)) u_addsub (
        .a   (a_i),
        .b   (b_i),
        .cin (as_cin),
        .sub (as_sub),
        .sum (as_sum),
        .cy  (as_cy),
        .ac  (as_ac),
        .ov  (as_ov)
    );

    aalu_logic #(.W(W)) u_logic (
        .a   (a_i),
        .b   (b_i),
        .sel (lg_sel),
        .res (lg_res)
    );

    aalu_muldiv #(.W(W)) u_muldiv (
        .a      (a_i),
        .b      (b_i),
        .is_div (op == OP_DIV),
        .lo     (md_lo),
        .hi     (md_hi),
        .ovf    (md_ovf)
    );

    // Choose the result bytes and apply the flag rule for each operation class.
    always_comb begin
        nx_lo = lg_res;
        nx_hi = b_i;
        nx_cy = cy_i;
        nx_ac = ac_i;
        nx_ov = ov_i;
        unique case (op)
            OP_ADD, OP_ADDC, OP_SUBB: begin
                nx_lo = as_sum;
                nx_cy = as_cy;
                nx_ac = as_ac;
                nx_ov = as_ov;
            end
            OP_MUL, OP_DIV: begin
                nx_lo = md_lo;
                nx_hi = md_hi;
                nx_cy = 1'b0;
                nx_ov = md_ovf;
            end
            default: begin
                nx_lo = lg_res;
            end
        endcase
    end

    // Output register with synchronous active-low reset; parity comes from the next accumulator value.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            res_lo_o <= '0;
            res_hi_o <= '0;
            cy_o     <= 1'b0;
            ac_o     <= 1'b0;
            ov_o     <= 1'b0;
            par_o    <= 1'b0;
        end else begin
            res_lo_o <= nx_lo;
            res_hi_o <= nx_hi;
            cy_o     <= nx_cy;
            ac_o     <= nx_ac;
            ov_o     <= nx_ov;
            par_o    <= ^nx_lo;
        end
    end

endmodule

// File: rtl/aalu_core_chk.sv
// Checker for aalu_core: temporal properties on its ports, bound to every instance.
module aalu_core_chk #(
    parameter int W = 8
) (
    input logic         clk,
    input logic         rst_n,
    input logic [2:0]   op_i,
    input logic [W-1:0] a_i,
    input logic [W-1:0] b_i,
    input logic         cy_i,
    input logic         ac_i,
    input logic         ov_i,
    input logic [W-1:0] res_lo_o,
    input logic [W-1:0] res_hi_o,
    input logic         cy_o,
    input logic         ac_o,
    input logic         ov_o,
    input logic         par_o
);
    // R1
    reset_clear_chk: assert property (@(posedge clk)
        !rst_n |=> (res_lo_o == '0 && res_hi_o == '0 && !cy_o && !ac_o && !ov_o && !par_o));

    // R7
    parity_chk: assert property (@(posedge clk) disable iff (!rst_n)
        par_o == ^res_lo_o);

    // R8
    logic_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op_i == 3'd3 || op_i == 3'd4 || op_i == 3'd5) |=>
        (cy_o == $past(cy_i) && ac_o == $past(ac_i) && ov_o == $past(ov_i)));

    // R9
    mul_product_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op_i == 3'd6) |=>
        ({res_hi_o, res_lo_o} == ((2*W)'($past(a_i)) * (2*W)'($past(b_i)))));

    // R10
    muldiv_carry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op_i == 3'd6 || op_i == 3'd7) |=> (!cy_o && ac_o == $past(ac_i)));

    // R11
    div_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op_i == 3'd7 && b_i == '0) |=>
        (ov_o && res_lo_o == $past(a_i) && res_hi_o == '0));

    // R12
    hi_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op_i <= 3'd5) |=> (res_hi_o == $past(b_i)));

endmodule

bind aalu_core aalu_core_chk #(.W(W)) u_aalu_core_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .op_i     (op_i),
    .a_i      (a_i),
    .b_i      (b_i),
    .cy_i     (cy_i),
    .ac_i     (ac_i),
    .ov_i     (ov_i),
    .res_lo_o (res_lo_o),
    .res_hi_o (res_hi_o),
    .cy_o     (cy_o),
    .ac_o     (ac_o),
    .ov_o     (ov_o),
    .par_o    (par_o)
);

// File: tb/aalu_core_bench.sv
`timescale 1ns/1ps
module aalu_core_bench;
    localparam int W = 8;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [2:0]   op_i = '0;
    logic [W-1:0] a_i = '0;
    logic [W-1:0] b_i = '0;
    logic         cy_i = 1'b0;
    logic         ac_i = 1'b0;
    logic         ov_i = 1'b0;
    logic [W-1:0] res_lo_o;
    logic [W-1:0] res_hi_o;
    logic         cy_o;
    logic         ac_o;
    logic         ov_o;
    logic         par_o;

    int n_checks = 0;
    int n_errors = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    aalu_core #(.W(W)) u_aalu_core (
        .clk(clk), .rst_n(rst_n), .op_i(op_i), .a_i(a_i), .b_i(b_i),
        .cy_i(cy_i), .ac_i(ac_i), .ov_i(ov_i),
        .res_lo_o(res_lo_o), .res_hi_o(res_hi_o),
        .cy_o(cy_o), .ac_o(ac_o), .ov_o(ov_o), .par_o(par_o)
    );

    task automatic check(input string tag, input string what, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_errors++;
            $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    // Reference model computed from the requirements.
    task automatic model(input int op, input int a, input int b, input int cin,
                         input int acin, input int ovin,
                         output int lo, output int hi, output int cy,
                         output int ac, output int ov);
        int c, full, sa, sb, sres, p;
        hi = b; cy = cin; ac = acin; ov = ovin; lo = 0;
        sa = (a > 127) ? a - 256 : a;
        sb = (b > 127) ? b - 256 : b;
        case (op)
            0, 1: begin
                c    = (op == 1) ? cin : 0;
                full = a + b + c;
                lo   = full & 255;
                cy   = (full > 255) ? 1 : 0;
                ac   = (((a & 15) + (b & 15) + c) > 15) ? 1 : 0;
                sres = sa + sb + c;
                ov   = (sres > 127 || sres < -128) ? 1 : 0;
            end
            2: begin
                full = a - b - cin;
                lo   = full & 255;
                cy   = (full < 0) ? 1 : 0;
                ac   = (((a & 15) - (b & 15) - cin) < 0) ? 1 : 0;
                sres = sa - sb - cin;
                ov   = (sres > 127 || sres < -128) ? 1 : 0;
            end
            3: lo = a & b;
            4: lo = a | b;
            5: lo = a ^ b;
            6: begin
                p  = a * b;
                lo = p & 255;
                hi = p / 256;
                cy = 0;
                ov = (p > 255) ? 1 : 0;
            end
            default: begin
                cy = 0;
                if (b == 0) begin
                    lo = a; hi = b; ov = 1;
                end else begin
                    lo = a / b; hi = a % b; ov = 0;
                end
            end
        endcase
    endtask

    function automatic int parity(input int v);
        int n = 0;
        for (int i = 0; i < 8; i++) n += (v >> i) & 1;
        return n & 1;
    endfunction

    task automatic run_vec(input int op, input int a, input int b, input int cin,
                           input int acin, input int ovin);
        int lo, hi, cy, ac, ov;
        string rt, ht, ft;
        @(negedge clk);
        op_i = op[2:0]; a_i = a[W-1:0]; b_i = b[W-1:0];
        cy_i = cin[0]; ac_i = acin[0]; ov_i = ovin[0];
        model(op, a, b, cin, acin, ovin, lo, hi, cy, ac, ov);
        @(posedge clk);
        #1;
        case (op)
            0, 1: begin rt = "R2/R3"; ht = "R12"; ft = "R4"; end
            2:    begin rt = "R6";    ht = "R12"; ft = "R4"; end
            3, 4, 5: begin rt = "R8"; ht = "R12"; ft = "R8"; end
            6:    begin rt = "R9";    ht = "R9";  ft = "R9"; end
            default: begin
                if (b == 0) begin rt = "R11"; ht = "R11"; ft = "R11"; end
                else        begin rt = "R10"; ht = "R10"; ft = "R10"; end
            end
        endcase
        check(rt, $sformatf("res_lo op%0d a=%0h b=%0h c=%0d", op, a, b, cin), int'(res_lo_o), lo);
        check(ht, $sformatf("res_hi op%0d a=%0h b=%0h", op, a, b), int'(res_hi_o), hi);
        check((op <= 2) ? "R3/R6" : ft, $sformatf("cy op%0d a=%0h b=%0h c=%0d", op, a, b, cin), int'(cy_o), cy);
        check(ft, $sformatf("ac op%0d a=%0h b=%0h c=%0d", op, a, b, cin), int'(ac_o), ac);
        check((op <= 2) ? "R5" : ft, $sformatf("ov op%0d a=%0h b=%0h c=%0d", op, a, b, cin), int'(ov_o), ov);
        check("R7", $sformatf("par op%0d a=%0h b=%0h", op, a, b), int'(par_o), parity(lo));
    endtask

    task automatic check_zero(input string what);
        check("R1", what, {res_lo_o, res_hi_o, cy_o, ac_o, ov_o, par_o}, 0);
    endtask

    // Watchdog: a hung run counts as a failure and still prints the summary.
    initial begin
        #(5.0 * 190000);
        if (!done) begin
            n_checks++;
            n_errors++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    end

    initial begin
        // R1: reset state
        repeat (3) @(posedge clk);
        #1;
        check_zero("outputs after reset");
        @(negedge clk);
        rst_n = 1'b1;

        // R2/R3: known small sum, result visible right after one edge
        run_vec(0, 8'h05, 8'h04, 0, 0, 0);
        check("R2", "05h+04h", int'(res_lo_o), 8'h09);

        // Directed flag corners
        run_vec(0, 8'h80, 8'h80, 0, 0, 0);   // R5 carry out, none in
        run_vec(0, 8'h40, 8'h40, 0, 0, 0);   // R5 carry in, none out
        run_vec(0, 8'hC0, 8'hC0, 0, 0, 0);   // R5 both carries
        run_vec(1, 8'h0F, 8'h00, 1, 0, 0);   // R4 carry from bit 3
        run_vec(2, 8'h10, 8'h00, 1, 0, 0);   // R4 borrow into bit 3
        run_vec(6, 8'hFF, 8'hFF, 1, 1, 0);   // R9
        run_vec(7, 8'hC8, 8'h00, 1, 1, 0);   // R11

        // Sweep: every accumulator value against a spread of second operands
        for (int op = 0; op < 8; op++)
            for (int a = 0; a < 256; a++)
                for (int k = 0; k < 16; k++)
                    for (int c = 0; c < 2; c++)
                        run_vec(op, a, k * 17, c, (a ^ k) & 1, ((a >> 1) ^ c) & 1);

        // R1: reset asserted in the middle of traffic
        @(negedge clk);
        op_i = 3'd0; a_i = 8'hFF; b_i = 8'h01; rst_n = 1'b0;
        @(posedge clk);
        #1;
        check_zero("outputs after mid-run reset");
        @(negedge clk);
        rst_n = 1'b1;
        run_vec(5, 8'hA5, 8'h0F, 0, 1, 1);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

endmodule